// File: doc/BRIEF.md
# Dual-Accumulator Saturating Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point signal-processing datapath. Two 16-bit operands are widened by one bit each and multiplied in a 17 x 17 signed multiplier. The widening is sign extension or zero extension, under the control of one mode bit. The product may be doubled to align a fractional 1.15 x 1.15 result to 1.31. It is then loaded into, added to or subtracted from one of two 40-bit accumulators. Every operation finishes in a single clock cycle.

Each accumulator carries eight guard bits above the 1.31 fraction. Saturation is enabled separately for each accumulator, and one mode bit sets where the clamp sits: either the 32-bit fractional range or the full 40-bit range. A status word reports guard-bit overflow and sticky saturation for each accumulator, together with the OR of each pair. A single clear strobe resets both sticky flags. No write path can set them.

Top module: `dual_acc_mac`

## Requirements
- R1: With `unsigned_i`=1 both operands are zero-extended to 17 bits; with `unsigned_i`=0 both are sign-extended, and the 17 x 17 product is signed.
- R2: With `frac_i`=1 the product is shifted left by one bit before use, so 0x8000 x 0x8000 gives exactly 0x0080000000 (+1.0) when saturation is off.
- R3: `op_i` encodes 0 = no operation, 1 = load product, 2 = add product, 3 = subtract product, 4 = clear to zero; codes 5 to 7 act as no operation. The result appears on the outputs after the next rising clock edge.
- R4: `dst_i`=0 selects accumulator A and `dst_i`=1 selects B; the accumulator that is not selected keeps its value.
- R5: With saturation disabled for the target accumulator, the result wraps modulo 2^40.
- R6: With saturation enabled (`sat_en_i[0]` for A, `sat_en_i[1]` for B) and `sat_wide_i`=0, a result outside [-2^31, 2^31-1] is clamped to 0xFF80000000 or 0x007FFFFFFF.
- R7: With saturation enabled and `sat_wide_i`=1, a result outside the 40-bit signed range is clamped to 0x8000000000 or 0x7FFFFFFFFF.
- R8: The overflow flags `status_o[0]` (A) and `status_o[1]` (B) are 1 while bits 39:31 of that accumulator are not all equal; `status_o[2]` is their OR.
- R9: The sticky saturation flags `status_o[3]` (A) and `status_o[4]` (B) are set by a clamp and hold until `stat_clr_i`, which clears both; a clamp in the same cycle as the clear leaves its flag set. `status_o[5]` is their OR.
- R10: After reset both accumulators and all status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| dst_i | input | 1 | Target accumulator (0 = A, 1 = B) |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| unsigned_i | input | 1 | 1 = zero-extend operands, 0 = sign-extend |
| frac_i | input | 1 | 1 = double the product (fractional alignment) |
| sat_en_i | input | 2 | Saturation enable, bit 0 for A, bit 1 for B |
| sat_wide_i | input | 1 | 0 = clamp at 32-bit range, 1 = clamp at 40-bit range |
| stat_clr_i | input | 1 | Clears both sticky saturation flags |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| status_o | output | 6 | Overflow and sticky saturation flags |

## Verification
The embedded properties are checked on every cycle. They cover the hold of the unselected or idle accumulator, a clear yielding zero, the narrow clamp keeping the guard bits equal to the sign, and the hold and release of the sticky flags. The bench scenarios are the only way to show the arithmetic: operand extension, the exact fractional product of -1.0 by -1.0, wraparound without saturation, and the precise clamp values in both modes. The same holds for the accumulation runs near the 40-bit limit and for the priority of a clamp over a simultaneous clear.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic [2:0] {
      OP_NOP = 3'd0,
      OP_MPY = 3'd1,
      OP_MAC = 3'd2,
      OP_MSC = 3'd3,
      OP_CLR = 3'd4
   } mac_op_e;

   function automatic logic op_is_write(input logic [2:0] code);
      return (code == OP_MPY) || (code == OP_MAC) || (code == OP_MSC) || (code == OP_CLR);
   endfunction
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int DATA_W = 16,
   parameter int ACC_W  = 40
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              unsigned_i,
   input  logic              frac_i,
   output logic [ACC_W-1:0]  prod_o
);
   localparam int XW   = DATA_W + 1;
   localparam int PW   = 2 * XW;
   localparam int PAD  = ACC_W - PW;

   generate
      if (PAD < 1) begin : g_bad_width
         $error("mac_mult: accumulator too narrow for shifted product");
      end
   endgenerate

   logic signed [XW-1:0] ax, bx;
   logic signed [PW-1:0] raw;
   logic        [ACC_W-1:0] ext;

   always_comb begin
      ax     = {(unsigned_i ? 1'b0 : a_i[DATA_W-1]), a_i};
      bx     = {(unsigned_i ? 1'b0 : b_i[DATA_W-1]), b_i};
      raw    = ax * bx;
      ext    = {{PAD{raw[PW-1]}}, raw};
      prod_o = frac_i ? (ext << 1) : ext;
   end
endmodule

// File: rtl/mac_acc_lane.sv
module mac_acc_lane
   import mac_pkg::*;
#(
   parameter int ACC_W      = 40,
   parameter int NARROW_MSB = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  mac_op_e          op_i,
   input  logic [ACC_W-1:0] prod_i,
   input  logic             sat_en_i,
   input  logic             sat_wide_i,
   input  logic             stat_clr_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             ovf_o,
   output logic             sat_o
);
   localparam int SW = ACC_W + 1;
   localparam int HI = ACC_W - NARROW_MSB;

   generate
      if (NARROW_MSB < 2 || NARROW_MSB >= ACC_W - 1) begin : g_bad_clamp
         $error("mac_acc_lane: clamp position out of range");
      end
   endgenerate

   logic [ACC_W-1:0] acc_q, acc_d, clamp_v;
   logic             sticky_q;
   logic signed [SW-1:0] acc_x, prod_x, sum;
   logic [SW-NARROW_MSB-1:0] sum_hi;
   logic             over_wide, over_narrow, sat_hit, neg;

   always_comb begin
      acc_x  = {acc_q[ACC_W-1], acc_q};
      prod_x = {prod_i[ACC_W-1], prod_i};
      case (op_i)
         OP_MPY:  sum = prod_x;
         OP_MAC:  sum = acc_x + prod_x;
         OP_MSC:  sum = acc_x - prod_x;
         default: sum = '0;
      endcase
      sum_hi      = sum[SW-1:NARROW_MSB];
      neg         = sum[SW-1];
      over_wide   = sum[SW-1] ^ sum[SW-2];
      over_narrow = ~((&sum_hi) | (~|sum_hi));
      sat_hit     = wr_i && sat_en_i && (sat_wide_i ? over_wide : over_narrow);
      if (sat_wide_i)
         clamp_v = neg ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
      else
         clamp_v = neg ? {{HI{1'b1}}, {NARROW_MSB{1'b0}}} : {{HI{1'b0}}, {NARROW_MSB{1'b1}}};
      acc_d = sat_hit ? clamp_v : sum[ACC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         sticky_q <= 1'b0;
      end else begin
         if (wr_i) acc_q <= acc_d;
         sticky_q <= (sticky_q & ~stat_clr_i) | sat_hit;
      end
   end

   assign acc_o = acc_q;
   assign sat_o = sticky_q;
   assign ovf_o = ~((&acc_q[ACC_W-1:NARROW_MSB]) | (~|acc_q[ACC_W-1:NARROW_MSB]));

   // R3: a clear leaves zero behind
   a_r3_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && op_i == OP_CLR) |=> (acc_q == '0));

   // R4: an accumulator that is not written keeps its value
   a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(acc_q));

   // R6: the narrow clamp keeps the guard bits equal to the sign
   a_r6_narrow_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sat_en_i && !sat_wide_i) |=>
         ((&acc_q[ACC_W-1:NARROW_MSB]) || (~|acc_q[ACC_W-1:NARROW_MSB])));

   // R9: a sticky flag holds until cleared
   a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q && !stat_clr_i) |=> sticky_q);

   // R9: the clear drops the flag unless a clamp happens at the same time
   a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr_i && !sat_hit) |=> !sticky_q);
endmodule

// File: rtl/dual_acc_mac.sv
module dual_acc_mac
   import mac_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int GUARD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_i,
   input  logic              dst_i,
   input  logic [15:0]       a_i,
   input  logic [15:0]       b_i,
   input  logic              unsigned_i,
   input  logic              frac_i,
   input  logic [1:0]        sat_en_i,
   input  logic              sat_wide_i,
   input  logic              stat_clr_i,
   output logic [39:0]       acc_a_o,
   output logic [39:0]       acc_b_o,
   output logic [5:0]        status_o
);
   localparam int ACC_W      = 2 * DATA_W + GUARD_W;
   localparam int NARROW_MSB = 2 * DATA_W - 1;
   localparam int N_ACC      = 2;

   generate
      if (DATA_W != 16 || ACC_W != 40) begin : g_bad_port
         $error("dual_acc_mac: port widths fixed at 16-bit data, 40-bit accumulators");
      end
      if (GUARD_W < 3) begin : g_bad_guard
         $error("dual_acc_mac: at least three guard bits needed");
      end
   endgenerate

   logic [ACC_W-1:0] prod;
   logic [ACC_W-1:0] acc [N_ACC];
   logic [N_ACC-1:0] ovf, sat;
   logic             valid_op;

   assign valid_op = op_is_write(op_i);

   mac_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_mult (
      .a_i        (a_i),
      .b_i        (b_i),
      .unsigned_i (unsigned_i),
      .frac_i     (frac_i),
      .prod_o     (prod)
   );

   for (genvar g = 0; g < N_ACC; g++) begin : g_lane
      mac_acc_lane #(.ACC_W(ACC_W), .NARROW_MSB(NARROW_MSB)) i_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_i       (valid_op && (dst_i == g[0])),
         .op_i       (mac_op_e'(op_i)),
         .prod_i     (prod),
         .sat_en_i   (sat_en_i[g]),
         .sat_wide_i (sat_wide_i),
         .stat_clr_i (stat_clr_i),
         .acc_o      (acc[g]),
         .ovf_o      (ovf[g]),
         .sat_o      (sat[g])
      );
   end

   assign acc_a_o  = acc[0];
   assign acc_b_o  = acc[1];
   assign status_o = {|sat, sat[1], sat[0], |ovf, ovf[1], ovf[0]};

   // R3: no-op and reserved codes leave both accumulators alone
   a_r3_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_op |=> ($stable(acc_a_o) && $stable(acc_b_o)));

   // R4: a write to A does not disturb B, and the reverse
   a_r4_dst_a: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_op && !dst_i) |=> $stable(acc_b_o));
   a_r4_dst_b: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_op && dst_i) |=> $stable(acc_a_o));
endmodule

// File: tb/test_dual_acc_mac.sv
module test_dual_acc_mac;
   typedef struct packed {
      logic [2:0]  op;
      logic        dst;
      logic [15:0] a;
      logic [15:0] b;
      logic        uns;
      logic        frac;
      logic [1:0]  sen;
      logic        wide;
      logic        clr;
      logic [39:0] ea;
      logic [39:0] eb;
      logic [5:0]  es;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{3'd1,1'b0,16'h0003,16'h0005,1'b0,1'b0,2'b00,1'b0,1'b0,40'h000000000F,40'h0000000000,6'h00},
      '{3'd1,1'b1,16'hFFFF,16'h0002,1'b0,1'b0,2'b00,1'b0,1'b0,40'h000000000F,40'hFFFFFFFFFE,6'h00},
      '{3'd2,1'b0,16'hFFFF,16'hFFFF,1'b1,1'b0,2'b00,1'b0,1'b0,40'h00FFFE0010,40'hFFFFFFFFFE,6'h05},
      '{3'd3,1'b0,16'hFFFF,16'hFFFF,1'b1,1'b0,2'b00,1'b0,1'b0,40'h000000000F,40'hFFFFFFFFFE,6'h00},
      '{3'd1,1'b0,16'h8000,16'h8000,1'b0,1'b1,2'b00,1'b0,1'b0,40'h0080000000,40'hFFFFFFFFFE,6'h05},
      '{3'd1,1'b1,16'h4000,16'h8000,1'b0,1'b1,2'b00,1'b0,1'b0,40'h0080000000,40'hFFC0000000,6'h05},
      '{3'd4,1'b0,16'h1234,16'h5678,1'b0,1'b0,2'b00,1'b0,1'b0,40'h0000000000,40'hFFC0000000,6'h00},
      '{3'd5,1'b0,16'h0007,16'h0007,1'b0,1'b0,2'b00,1'b0,1'b0,40'h0000000000,40'hFFC0000000,6'h00},
      '{3'd1,1'b0,16'h8000,16'h8000,1'b0,1'b1,2'b01,1'b0,1'b0,40'h007FFFFFFF,40'hFFC0000000,6'h28},
      '{3'd2,1'b0,16'h7FFF,16'h7FFF,1'b0,1'b1,2'b01,1'b0,1'b0,40'h007FFFFFFF,40'hFFC0000000,6'h28},
      '{3'd0,1'b0,16'h0000,16'h0000,1'b0,1'b0,2'b00,1'b0,1'b1,40'h007FFFFFFF,40'hFFC0000000,6'h00},
      '{3'd3,1'b1,16'h7FFF,16'h7FFF,1'b0,1'b1,2'b10,1'b0,1'b0,40'h007FFFFFFF,40'hFF80000000,6'h30},
      '{3'd2,1'b0,16'h7FFF,16'h7FFF,1'b0,1'b1,2'b00,1'b0,1'b0,40'h00FFFE0001,40'hFF80000000,6'h35}
   };
   localparam string VTAG [NV] = '{"R3 R1","R1 R4","R1 R8","R3 R1","R2 R8","R2 R4",
                                   "R3 clr","R3 reserved","R6 R2 R9","R6 R9","R9 clear",
                                   "R6 R9","R5 R8"};

   logic clk = 1'b0, rst_n = 1'b0;
   logic [2:0] op_i = '0;
   logic dst_i = 1'b0, unsigned_i = 1'b0, frac_i = 1'b0, sat_wide_i = 1'b0, stat_clr_i = 1'b0;
   logic [15:0] a_i = '0, b_i = '0;
   logic [1:0] sat_en_i = '0;
   logic [39:0] acc_a_o, acc_b_o;
   logic [5:0] status_o;
   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   dual_acc_mac i_dual_acc_mac (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .dst_i(dst_i), .a_i(a_i), .b_i(b_i),
      .unsigned_i(unsigned_i), .frac_i(frac_i), .sat_en_i(sat_en_i),
      .sat_wide_i(sat_wide_i), .stat_clr_i(stat_clr_i),
      .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .status_o(status_o));

   task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic step(input logic [2:0] op, input logic dst, input logic [15:0] a,
                       input logic [15:0] b, input logic uns, input logic frac,
                       input logic [1:0] sen, input logic wide, input logic clr);
      op_i = op; dst_i = dst; a_i = a; b_i = b; unsigned_i = uns; frac_i = frac;
      sat_en_i = sen; sat_wide_i = wide; stat_clr_i = clr;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [39:0] p, model;
      p = 40'h01FFFC0002;   // 0xFFFF*0xFFFF unsigned, doubled
      repeat (2) @(negedge clk);
      check("R10 reset A", acc_a_o, '0);
      check("R10 reset B", acc_b_o, '0);
      check("R10 reset status", {34'd0, status_o}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         step(VECS[i].op, VECS[i].dst, VECS[i].a, VECS[i].b, VECS[i].uns, VECS[i].frac,
              VECS[i].sen, VECS[i].wide, VECS[i].clr);
         check({VTAG[i], " A"}, acc_a_o, VECS[i].ea);
         check({VTAG[i], " B"}, acc_b_o, VECS[i].eb);
         check({VTAG[i], " status"}, {34'd0, status_o}, {34'd0, VECS[i].es});
      end

      // R9 clear keeps R8 overflow flag
      step(3'd0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1);
      check("R9 clear leaves R8", {34'd0, status_o}, 40'h05);

      // R7 wide clamp, positive direction
      step(3'd4, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
      step(3'd4, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
      for (int k = 0; k < 64; k++)
         step(3'd2, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 2'b01, 1'b1, 1'b0);
      model = '0;
      for (int k = 0; k < 64; k++) model = model + p;
      check("R7 below limit A", acc_a_o, model);
      check("R7 below limit status", {34'd0, status_o}, 40'h05);
      for (int k = 0; k < 2; k++)
         step(3'd2, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 2'b01, 1'b1, 1'b0);
      check("R7 clamp high A", acc_a_o, 40'h7FFFFFFFFF);
      check("R7 R9 status", {34'd0, status_o}, 40'h2D);

      // R9 clamp in same cycle as clear keeps the flag
      step(3'd2, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 2'b01, 1'b1, 1'b1);
      check("R9 clamp beats clear", {34'd0, status_o}, 40'h2D);
      check("R7 still clamped", acc_a_o, 40'h7FFFFFFFFF);
      step(3'd0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1);
      check("R9 clear after", {34'd0, status_o}, 40'h05);

      // R7 wide clamp, negative direction on B
      for (int k = 0; k < 66; k++)
         step(3'd3, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0);
      check("R7 clamp low B", acc_b_o, 40'h8000000000);
      check("R7 R8 R9 status", {34'd0, status_o}, 40'h37);

      // R5 wrap with saturation off
      step(3'd4, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
      for (int k = 0; k < 66; k++)
         step(3'd2, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0);
      model = '0;
      for (int k = 0; k < 66; k++) model = model + p;
      check("R5 wrap A", acc_a_o, model);
      check("R5 no sticky A", {34'd0, status_o}, 40'h37);

      // R10 reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 re-reset A", acc_a_o, '0);
      check("R10 re-reset status", {34'd0, status_o}, '0);
      finish_run();
   end
endmodule